// File: doc/BRIEF.md
# Serial RAM Power-Up Sequencer

This block sits on the host side of a serial pseudo-SRAM link. It holds the memory's pins until the memory can accept its first command. While the supply is not yet good, and then for a programmable settling interval after it turns good, the block drives fixed idle levels: chip select inactive (high), serial clock low, and all four data lines driven low. When the interval ends, it toggles the serial clock a set number of times with chip select still high. The memory needs at least one such toggle to finish its internal reset. The block then raises a ready flag.

Once ready is high, the block hands the pins to the downstream command controller through a select output. It also lets go of the data lines by dropping their output enables. At hand-over the memory is always in single-bit SPI mode, so the downstream controller must start in that mode. The supply-good input passes through a small synchronizer. If it falls at any time, even for a single cycle, ready drops, the pins return to the idle levels under this block's control, and the whole sequence starts again from the beginning.

The settling interval is set in system-clock cycles. By default it is derived from the clock frequency and a duration in microseconds, rounded up. With a 100 MHz clock and 150 µs, the default is 15000 cycles.

Top module: `psram_pwrup_seq`

## Requirements
- R1: Whenever the block owns the pins and is not toggling the serial clock, it drives ram_cs_n=1, ram_sclk=0, ram_dq_out=0 and ram_dq_oe all ones.
- R2: SETTLE_CYCLES defaults to ceil(CLK_FREQ_HZ*SETTLE_US/1e6), with a minimum of 1. The first ram_sclk rise comes at the clock edge SYNC_STAGES+SETTLE_CYCLES edges after the first edge that samples supply_good high.
- R3: After settling, ram_sclk makes PULSES pulses, each HALF_CYCLES cycles high and then HALF_CYCLES cycles low. ram_cs_n stays 1 throughout, and no other ram_sclk rise occurs before ready.
- R4: ready and handoff_sel rise together at the edge that ends the last low phase, that is 2*HALF_CYCLES*PULSES edges after the first ram_sclk rise.
- R5: While ready is 1, ram_dq_oe is all zeros, ram_dq_out is 0, ram_sclk is 0 and ram_cs_n is 1. These levels stay unchanged for as long as supply_good stays high.
- R6: When supply_good goes low while ready is 1, ready and handoff_sel fall SYNC_STAGES edges after the first edge that samples it low. The R1 idle levels return at that same edge.
- R7: A loss of supply_good during the settling interval or during the pulse phase aborts the sequence. When the supply returns, timing restarts in full from the new rise as in R2 to R4, even after a one-cycle glitch.
- R8: While rst_n is low, the outputs hold the R1 idle levels with ready and handoff_sel at 0.
- R9: While supply_good stays low, ram_sclk stays 0 and ready stays 0 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_good | input | 1 | Supply-stable indication, may be asynchronous |
| ram_cs_n | output | 1 | Memory chip select, active low (held inactive) |
| ram_sclk | output | 1 | Memory serial clock |
| ram_dq_out | output | DQ_W (4) | Data line output values |
| ram_dq_oe | output | DQ_W (4) | Data line output enables, one per line |
| ready | output | 1 | Memory initialised and in SPI mode |
| handoff_sel | output | 1 | Pin mux select: 1 gives the pins to the downstream controller |

## Verification
The bench builds the block with CLK_FREQ_HZ=1_000_000 and SETTLE_US=20. This keeps the derived-interval function in the path and gives a 20-cycle settle that the bench recomputes on its own. HALF_CYCLES=3 makes each pulse phase several cycles long, so pulse width, the single pulse count and the exact ready edge can all be checked sample by sample. A two-stage synchronizer makes a one-cycle supply glitch land on exactly the same restart timing as a clean rise, and the bench uses this to check the full-restart rule exactly.

// File: rtl/psram_pwrup_pkg.sv
package psram_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_SCLK_HI = 3'd2,
    ST_SCLK_LO = 3'd3,
    ST_READY   = 3'd4
  } pwr_state_e;

  // Settling cycles from frequency (Hz) and duration (us), rounded up, at least 1.
  function automatic int unsigned settle_cycles(input longint unsigned freq_hz,
                                                input longint unsigned dur_us);
    longint unsigned prod;
    longint unsigned cyc;
    prod = freq_hz * dur_us;
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

  // R6/R7: a rising synchronized level always reflects an input that was high
  a_r7_sync_rise_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(din, STAGES));
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  import psram_pwrup_pkg::*;
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (run)        cnt <= expired ? '0 : cnt + 1'b1;
  end

  // R2/R3: each window restarts from zero after it expires
  a_r2_wrap_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> (cnt == '0));
endmodule

// File: rtl/pwrup_pins.sv
module pwrup_pins #(
  parameter int unsigned DQ_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drive_sclk,
  input  logic            release_pins,
  output logic            cs_n,
  output logic            sclk,
  output logic [DQ_W-1:0] dq_out,
  output logic [DQ_W-1:0] dq_oe,
  output logic            ready,
  output logic            handoff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      dq_out  <= '0;
      dq_oe   <= '1;
      ready   <= 1'b0;
      handoff <= 1'b0;
    end else begin
      cs_n    <= 1'b1;
      sclk    <= drive_sclk && !release_pins;
      dq_out  <= '0;
      dq_oe   <= release_pins ? '0 : '1;
      ready   <= release_pins;
      handoff <= release_pins;
    end
  end

  // R5: the clock is never toggled once the pins are handed over
  a_r5_no_sclk_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !sclk);
endmodule

// File: rtl/psram_pwrup_seq.sv
module psram_pwrup_seq
  import psram_pwrup_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ   = 100_000_000,
  parameter int unsigned SETTLE_US     = 150,
  parameter int unsigned SETTLE_CYCLES = settle_cycles(64'(CLK_FREQ_HZ), 64'(SETTLE_US)),
  parameter int unsigned HALF_CYCLES   = 2,
  parameter int unsigned PULSES        = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned DQ_W          = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_good,
  output logic            ram_cs_n,
  output logic            ram_sclk,
  output logic [DQ_W-1:0] ram_dq_out,
  output logic [DQ_W-1:0] ram_dq_oe,
  output logic            ready,
  output logic            handoff_sel
);
  localparam int unsigned PW = cnt_width(PULSES);
  localparam int unsigned RW = cnt_width(PULSES + 2);
  localparam logic [PW-1:0] LAST_PULSE = PW'(PULSES - 1);

  // Named internal events
  logic       sup_ok;
  logic       settle_run, settle_done;
  logic       half_run, half_done;
  logic       last_pulse;
  logic       sclk_rise_evt;
  pwr_state_e state, state_n;
  logic [PW-1:0] pulse_idx;
  logic [RW-1:0] rise_cnt;
  logic          sclk_prev;

  pwrup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(supply_good), .dout(sup_ok));

  assign settle_run = (state == ST_SETTLE);
  assign half_run   = (state == ST_SCLK_HI) || (state == ST_SCLK_LO);

  pwrup_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .clear(!settle_run), .run(settle_run),
    .expired(settle_done));

  pwrup_timer #(.LIMIT(HALF_CYCLES)) u_half (
    .clk(clk), .rst_n(rst_n), .clear(!half_run), .run(half_run),
    .expired(half_done));

  assign last_pulse = (pulse_idx == LAST_PULSE);

  always_comb begin
    state_n = state;
    if (!sup_ok) begin
      state_n = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     state_n = ST_SETTLE;
        ST_SETTLE:  if (settle_done) state_n = ST_SCLK_HI;
        ST_SCLK_HI: if (half_done)   state_n = ST_SCLK_LO;
        ST_SCLK_LO: if (half_done)   state_n = last_pulse ? ST_READY : ST_SCLK_HI;
        ST_READY:   state_n = ST_READY;
        default:    state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pulse_idx <= '0;
    else if (state == ST_OFF)                pulse_idx <= '0;
    else if (state == ST_SCLK_LO && half_done && !last_pulse)
                                             pulse_idx <= pulse_idx + 1'b1;
  end

  pwrup_pins #(.DQ_W(DQ_W)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .drive_sclk(state_n == ST_SCLK_HI),
    .release_pins(state_n == ST_READY),
    .cs_n(ram_cs_n), .sclk(ram_sclk), .dq_out(ram_dq_out), .dq_oe(ram_dq_oe),
    .ready(ready), .handoff(handoff_sel));

  // Independent observer of pin activity, used by the assertions below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= ram_sclk;
  end
  assign sclk_rise_evt = ram_sclk && !sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rise_cnt <= '0;
    else if (state == ST_OFF)   rise_cnt <= '0;
    else if (sclk_rise_evt)     rise_cnt <= rise_cnt + 1'b1;
  end

  // R4: ready only rises after exactly PULSES clock rises in this attempt
  a_r4_ready_after_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (rise_cnt == RW'(PULSES)));

  // R6: losing the synchronized supply removes ready at the next edge
  a_r6_supply_loss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (!ready && !handoff_sel));

  // R1: during settling the pins sit at their idle levels
  a_r1_settle_idle: assert property (@(posedge clk) disable iff (!rst_n)
    settle_run |-> (!ram_sclk && ram_cs_n && ram_dq_oe == '1 && ram_dq_out == '0));

  // R3: chip select is inactive whenever the serial clock is high
  a_r3_sclk_with_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sclk |-> ram_cs_n);

  // R4: hand-over select tracks ready
  a_r4_handoff_matches_ready: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_sel == ready);
endmodule

// File: tb/sim_psram_pwrup_seq.sv
module sim_psram_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ  = 1_000_000;
  localparam int DUR   = 20;
  localparam int HALF  = 3;
  localparam int NPULS = 1;
  localparam int SYNC  = 2;
  // Restated independently: ceil(1e6 * 20 / 1e6) = 20
  localparam int SETTLE = (FREQ * DUR + 999_999) / 1_000_000;
  localparam int T_RISE  = SYNC + SETTLE;
  localparam int T_READY = T_RISE + 2 * HALF * NPULS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic       ram_cs_n, ram_sclk, ready, handoff_sel;
  logic [3:0] ram_dq_out, ram_dq_oe;

  int checks = 0;
  int errors = 0;

  localparam logic [11:0] V_IDLE  = {1'b1, 1'b0, 4'h0, 4'hF, 1'b0, 1'b0};
  localparam logic [11:0] V_SCLK  = {1'b1, 1'b1, 4'h0, 4'hF, 1'b0, 1'b0};
  localparam logic [11:0] V_READY = {1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b1};

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_pwrup_seq #(
    .CLK_FREQ_HZ(FREQ), .SETTLE_US(DUR), .HALF_CYCLES(HALF),
    .PULSES(NPULS), .SYNC_STAGES(SYNC), .DQ_W(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
    .ram_cs_n(ram_cs_n), .ram_sclk(ram_sclk), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ready(ready), .handoff_sel(handoff_sel));

  function automatic logic [11:0] pins();
    return {ram_cs_n, ram_sclk, ram_dq_out, ram_dq_oe, ready, handoff_sel};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected pin vector j samples after the edge that first sees supply high
  function automatic logic [11:0] profile(input int j);
    if (j >= T_READY) return V_READY;
    for (int p = 0; p < NPULS; p++)
      if (j >= T_RISE + 2*HALF*p && j < T_RISE + 2*HALF*p + HALF) return V_SCLK;
    return V_IDLE;
  endfunction

  // Called at a negedge right after supply_good was raised
  task automatic expect_profile(input int start_j, input string req);
    int rises = 0;
    logic prev = 1'b0;
    for (int j = 0; j <= T_READY + 4; j++) begin
      @(negedge clk);
      if (j >= start_j) begin
        check(req, 32'(pins()), 32'(profile(j)), $sformatf("pins at sample %0d", j));
        if (ram_sclk && !prev && ram_cs_n && !ready) rises++;
      end
      prev = ram_sclk;
    end
    check("R3", 32'(rises), 32'(NPULS), "sclk rises with cs high before ready");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    supply_good = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", 32'(pins()), 32'(V_IDLE), "pins in reset");
    supply_good = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_no_supply();
    for (int j = 0; j < 60; j++) begin
      @(negedge clk);
      if (ram_sclk || ready) begin
        check("R9", 32'(pins()), 32'(V_IDLE), "pins without supply");
        return;
      end
    end
    check("R9", 32'(pins()), 32'(V_IDLE), "pins after 60 cycles without supply");
  endtask

  task automatic t_full_sequence();
    check("R2", 32'(SETTLE), 32'd20, "derived settle cycles restated");
    supply_good = 1'b1;
    expect_profile(0, "R1 R2 R3 R4");
    for (int j = 0; j < 30; j++) @(negedge clk);
    check("R5", 32'(pins()), 32'(V_READY), "pins held after ready");
  endtask

  task automatic t_drop_after_ready();
    supply_good = 1'b0;
    for (int j = 0; j <= SYNC + 2; j++) begin
      @(negedge clk);
      check("R6", 32'(pins()), 32'((j < SYNC) ? V_READY : V_IDLE),
            $sformatf("pins %0d samples after drop", j));
    end
    repeat (5) @(negedge clk);
    supply_good = 1'b1;
    expect_profile(0, "R6");
  endtask

  task automatic t_drop_in_settle();
    supply_good = 1'b0;
    repeat (8) @(negedge clk);
    supply_good = 1'b1;
    repeat (10) @(negedge clk);
    supply_good = 1'b0;
    for (int j = 0; j < T_READY + 5; j++) begin
      @(negedge clk);
      if (ram_sclk || ready) break;
    end
    check("R7", 32'(pins()), 32'(V_IDLE), "no pulse or ready after drop in settle");
    supply_good = 1'b1;
    expect_profile(0, "R7");
  endtask

  task automatic t_glitch_in_pulse();
    supply_good = 1'b0;
    repeat (6) @(negedge clk);
    supply_good = 1'b1;
    for (int j = 0; j <= T_RISE; j++) @(negedge clk);
    check("R3", 32'(pins()), 32'(V_SCLK), "sclk high before glitch");
    supply_good = 1'b0;
    @(negedge clk);
    supply_good = 1'b1;
    expect_profile(1, "R7");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_no_supply();
    t_full_sequence();
    t_drop_after_ready();
    t_drop_in_settle();
    t_glitch_in_pulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule